// File: doc/BRIEF.md
# SDRAM Power-Up Initialization Sequencer

This block brings a bank of SDRAM chip groups from power-on to a usable state. Releasing reset counts as power-on. The block first holds the command bus in command-inhibit for a programmable settling time counted in clocks. It then issues one NOP and a precharge of all banks to every chip group. Next come two auto-refresh commands for each chip group in turn, and finally a load of the mode register. Required spacings are kept between these commands, and NOP is driven on every idle cycle.

The mode register word is built at elaboration time from parameters:
- burst length
- burst type (sequential or interleaved)
- CAS latency
- write burst mode

The settling time and the precharge, refresh-cycle and mode-load spacings are also parameters in clocks. When the last spacing has elapsed, `initDone` goes high and stays high, telling the access sequencer that it may take over the command bus. After that point this block only drives NOP.

All bus outputs come from registers. A command therefore appears one clock after the control state that requests it.

Top module: `sdram_powerup_init`

## Requirements
- R1: While reset is asserted, and through clock edge `WAIT_CYC` after reset release (edges counted from 1), the bus is in command-inhibit: every `sdCsN` bit is 1, RAS/CAS/WE are 1/1/1, `sdCke` is 1 and `initDone` is 0.
- R2: At edge `WAIT_CYC+1`, exactly one NOP is driven: all `sdCsN` bits are 0 and RAS/CAS/WE are 1/1/1.
- R3: At edge `WAIT_CYC+2`, a precharge-all is issued: RAS/CAS/WE are 0/1/0, all `sdCsN` bits are 0, `sdAddr[10]`=1, all other address bits are 0, and `sdBa`=0.
- R4: An auto-refresh drives RAS/CAS/WE as 0/0/1, address and bank 0, and pulls low exactly one chip-select bit, the one for the group being refreshed.
- R5: Exactly two auto-refreshes go to each chip group. Group 0 is refreshed first and groups follow in ascending index; both refreshes of a group finish before the next group starts.
- R6: The first refresh comes `T_RP` edges after the precharge. Each later refresh, and the mode load, come `T_RC` edges after the preceding refresh.
- R7: The mode load drives RAS/CAS/WE as 0/0/0, all `sdCsN` bits 0 and `sdBa`=0.
- R8: The mode load address word is laid out as follows:
  - `sdAddr[2:0]`: burst-length code (1→000, 2→001, 4→010, 8→011)
  - `sdAddr[3]`: burst type
  - `sdAddr[6:4]`: CAS latency
  - `sdAddr[8:7]`: 00
  - `sdAddr[9]`: write burst mode
  - all higher address bits: 0
- R9: After the power-up wait, every cycle that carries no command is a NOP with all chip selects low, and `sdCke` stays 1 on every cycle.
- R10: `initDone` rises exactly `T_MRD` edges after the mode load and stays high until reset. From then on, only NOP is driven.
- R11: Asserting reset part way through the sequence returns the bus to command-inhibit with `initDone` low at once. After release, the full sequence restarts from the power-up wait.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset; its release marks power-on |
| sdCke | output | 1 | Clock enable to the memory |
| sdCsN | output | GROUPS | Active-low chip select, one per chip group |
| sdRasN | output | 1 | Active-low row strobe |
| sdCasN | output | 1 | Active-low column strobe |
| sdWeN | output | 1 | Active-low write enable |
| sdBa | output | BANK_W | Bank address |
| sdAddr | output | ADDR_W | Multiplexed address, carries the mode word during the mode load |
| initDone | output | 1 | High once initialization has completed |

## Verification
The bench uses a 40-cycle power-up wait instead of the full settling time, so every edge of the sequence can be checked in a short run. Two chip groups make the per-group chip-select pattern and the group order observable. The distinct spacings 3, 5 and 2 mean that any swap or misuse of the precharge, refresh and mode-load gaps moves a command to a cycle where a NOP is expected. Burst length 4, interleaved burst type, CAS latency 3 and single-write mode set nonzero values in every mode field, so a misplaced field changes the checked address word.

// File: rtl/sdinit_pkg.sv
`timescale 1ns/1ps
package sdinit_pkg;

  // Command requested by the control FSM for the next bus cycle
  typedef enum logic [2:0] {
    CMD_INHIBIT,
    CMD_NOP,
    CMD_PRECHARGE,
    CMD_REFRESH,
    CMD_LOADMODE
  } busCmd_e;

  // Strobes passed from control to the bus datapath
  typedef struct packed {
    busCmd_e cmd;
    logic    markDone;
  } seqStrobe_t;

  // Mode word burst-length code: 1->000, 2->001, 4->010, 8->011
  function automatic logic [2:0] burstCode(input int unsigned len);
    case (len)
      1:       return 3'b000;
      2:       return 3'b001;
      4:       return 3'b010;
      default: return 3'b011;
    endcase
  endfunction

endpackage

// File: rtl/sdinit_ctrl.sv
`timescale 1ns/1ps
module sdinit_ctrl
  import sdinit_pkg::*;
#(
  parameter int unsigned WAIT_CYC = 20000,
  parameter int unsigned T_RP     = 3,
  parameter int unsigned T_RC     = 9,
  parameter int unsigned T_MRD    = 2,
  parameter int unsigned GROUPS   = 2,
  localparam int unsigned GRP_W   = (GROUPS > 1) ? $clog2(GROUPS) : 1
) (
  input  logic             clk,
  input  logic             rstN,
  output seqStrobe_t       strobe,
  output logic [GRP_W-1:0] refGroup
);

  localparam int unsigned REF_TOTAL = 2 * GROUPS;
  localparam int unsigned REF_W     = $clog2(REF_TOTAL + 1);
  localparam int unsigned WAIT_W    = $clog2(WAIT_CYC + 1);
  localparam int unsigned GAP_MAX   = (T_RC > T_RP) ? ((T_RC > T_MRD) ? T_RC : T_MRD)
                                                    : ((T_RP > T_MRD) ? T_RP : T_MRD);
  localparam int unsigned GAP_W     = $clog2(GAP_MAX + 1);

  typedef enum logic [2:0] {
    ST_WAIT, ST_NOP, ST_PRE, ST_REF, ST_MRS, ST_GAP, ST_DONE
  } seqState_e;

  seqState_e         state;
  seqState_e         gapNext;
  logic [WAIT_W-1:0] waitCnt;
  logic [GAP_W-1:0]  gapCnt;
  logic [REF_W-1:0]  refCnt;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state   <= ST_WAIT;
      gapNext <= ST_WAIT;
      waitCnt <= '0;
      gapCnt  <= '0;
      refCnt  <= '0;
    end else begin
      case (state)
        ST_WAIT: begin
          if (waitCnt == WAIT_W'(WAIT_CYC - 1)) state <= ST_NOP;
          else waitCnt <= waitCnt + 1'b1;
        end
        ST_NOP: state <= ST_PRE;
        ST_PRE: begin
          if (T_RP > 1) begin
            state   <= ST_GAP;
            gapCnt  <= GAP_W'(T_RP - 1);
            gapNext <= ST_REF;
          end else begin
            state <= ST_REF;
          end
        end
        ST_REF: begin
          refCnt <= refCnt + 1'b1;
          if (T_RC > 1) begin
            state   <= ST_GAP;
            gapCnt  <= GAP_W'(T_RC - 1);
            gapNext <= (refCnt == REF_W'(REF_TOTAL - 1)) ? ST_MRS : ST_REF;
          end else begin
            state <= (refCnt == REF_W'(REF_TOTAL - 1)) ? ST_MRS : ST_REF;
          end
        end
        ST_MRS: begin
          if (T_MRD > 1) begin
            state   <= ST_GAP;
            gapCnt  <= GAP_W'(T_MRD - 1);
            gapNext <= ST_DONE;
          end else begin
            state <= ST_DONE;
          end
        end
        ST_GAP: begin
          if (gapCnt == GAP_W'(1)) state <= gapNext;
          else gapCnt <= gapCnt - 1'b1;
        end
        default: state <= ST_DONE;
      endcase
    end
  end

  always_comb begin
    strobe.markDone = (state == ST_DONE);
    case (state)
      ST_WAIT: strobe.cmd = CMD_INHIBIT;
      ST_PRE:  strobe.cmd = CMD_PRECHARGE;
      ST_REF:  strobe.cmd = CMD_REFRESH;
      ST_MRS:  strobe.cmd = CMD_LOADMODE;
      default: strobe.cmd = CMD_NOP;
    endcase
  end

  // Two refreshes per group, so the group index is the refresh count halved
  assign refGroup = GRP_W'(refCnt >> 1);

  AST_NOP_AFTER_FULL_WAIT: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_NOP) |-> ($past(state) == ST_WAIT && $past(waitCnt) == WAIT_W'(WAIT_CYC - 1))); // R2

  AST_REF_COUNT_BOUND: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_MRS) |-> (refCnt == REF_W'(REF_TOTAL))); // R5

endmodule

// File: rtl/sdinit_bus.sv
`timescale 1ns/1ps
module sdinit_bus
  import sdinit_pkg::*;
#(
  parameter int unsigned GROUPS      = 2,
  parameter int unsigned ADDR_W      = 13,
  parameter int unsigned BANK_W      = 2,
  parameter int unsigned BURST_LEN   = 4,
  parameter int unsigned BURST_TYPE  = 0,
  parameter int unsigned CAS_LAT     = 3,
  parameter int unsigned WRITE_BURST = 0,
  localparam int unsigned GRP_W      = (GROUPS > 1) ? $clog2(GROUPS) : 1
) (
  input  logic              clk,
  input  logic              rstN,
  input  seqStrobe_t        strobe,
  input  logic [GRP_W-1:0]  refGroup,
  output logic              sdCke,
  output logic [GROUPS-1:0] sdCsN,
  output logic              sdRasN,
  output logic              sdCasN,
  output logic              sdWeN,
  output logic [BANK_W-1:0] sdBa,
  output logic [ADDR_W-1:0] sdAddr,
  output logic              initDone
);

  localparam logic [2:0] CAS_FIELD = CAS_LAT[2:0];
  localparam logic [9:0] MODE_LOW  = {WRITE_BURST[0], 2'b00, CAS_FIELD, BURST_TYPE[0],
                                      burstCode(BURST_LEN)};
  localparam logic [ADDR_W-1:0] MODE_WORD = {{(ADDR_W - 10){1'b0}}, MODE_LOW};
  localparam logic [ADDR_W-1:0] PRE_ALL   = {{(ADDR_W - 11){1'b0}}, 1'b1, 10'b0};

  logic [GROUPS-1:0] refSelN;
  assign refSelN = ~(GROUPS'(1) << refGroup);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      sdCke    <= 1'b1;
      sdCsN    <= '1;
      sdRasN   <= 1'b1;
      sdCasN   <= 1'b1;
      sdWeN    <= 1'b1;
      sdBa     <= '0;
      sdAddr   <= '0;
      initDone <= 1'b0;
    end else begin
      sdCke    <= 1'b1;
      sdBa     <= '0;
      initDone <= initDone | strobe.markDone;
      case (strobe.cmd)
        CMD_INHIBIT: begin
          sdCsN <= '1; {sdRasN, sdCasN, sdWeN} <= 3'b111; sdAddr <= '0;
        end
        CMD_PRECHARGE: begin
          sdCsN <= '0; {sdRasN, sdCasN, sdWeN} <= 3'b010; sdAddr <= PRE_ALL;
        end
        CMD_REFRESH: begin
          sdCsN <= refSelN; {sdRasN, sdCasN, sdWeN} <= 3'b001; sdAddr <= '0;
        end
        CMD_LOADMODE: begin
          sdCsN <= '0; {sdRasN, sdCasN, sdWeN} <= 3'b000; sdAddr <= MODE_WORD;
        end
        default: begin
          sdCsN <= '0; {sdRasN, sdCasN, sdWeN} <= 3'b111; sdAddr <= '0;
        end
      endcase
    end
  end

  AST_INHIBIT_IS_QUIET: assert property (@(posedge clk) disable iff (!rstN)
    (&sdCsN) |-> (sdRasN && sdCasN && sdWeN && !initDone)); // R1

  AST_PRECHARGE_ALL: assert property (@(posedge clk) disable iff (!rstN)
    (!sdRasN && sdCasN && !sdWeN) |-> (sdCsN == '0 && sdAddr[10])); // R3

  AST_REFRESH_ONE_GROUP: assert property (@(posedge clk) disable iff (!rstN)
    (!sdRasN && !sdCasN && sdWeN) |-> ($countones(~sdCsN) == 1)); // R4

  AST_DONE_STICKY: assert property (@(posedge clk) disable iff (!rstN)
    initDone |=> initDone); // R10

  AST_IDLE_AFTER_DONE: assert property (@(posedge clk) disable iff (!rstN)
    initDone |-> (sdCsN == '0 && sdRasN && sdCasN && sdWeN)); // R10

endmodule

// File: rtl/sdram_powerup_init.sv
`timescale 1ns/1ps
module sdram_powerup_init
  import sdinit_pkg::*;
#(
  parameter int unsigned WAIT_CYC    = 20000,
  parameter int unsigned T_RP        = 3,
  parameter int unsigned T_RC        = 9,
  parameter int unsigned T_MRD       = 2,
  parameter int unsigned GROUPS      = 2,
  parameter int unsigned ADDR_W      = 13,
  parameter int unsigned BANK_W      = 2,
  parameter int unsigned BURST_LEN   = 4,
  parameter int unsigned BURST_TYPE  = 0,
  parameter int unsigned CAS_LAT     = 3,
  parameter int unsigned WRITE_BURST = 0
) (
  input  logic              clk,
  input  logic              rstN,
  output logic              sdCke,
  output logic [GROUPS-1:0] sdCsN,
  output logic              sdRasN,
  output logic              sdCasN,
  output logic              sdWeN,
  output logic [BANK_W-1:0] sdBa,
  output logic [ADDR_W-1:0] sdAddr,
  output logic              initDone
);

  localparam int unsigned GRP_W = (GROUPS > 1) ? $clog2(GROUPS) : 1;

  seqStrobe_t       seqStrobe;
  logic [GRP_W-1:0] refGroup;

  sdinit_ctrl #(
    .WAIT_CYC(WAIT_CYC), .T_RP(T_RP), .T_RC(T_RC), .T_MRD(T_MRD), .GROUPS(GROUPS)
  ) i_ctrl (
    .clk(clk), .rstN(rstN), .strobe(seqStrobe), .refGroup(refGroup)
  );

  sdinit_bus #(
    .GROUPS(GROUPS), .ADDR_W(ADDR_W), .BANK_W(BANK_W), .BURST_LEN(BURST_LEN),
    .BURST_TYPE(BURST_TYPE), .CAS_LAT(CAS_LAT), .WRITE_BURST(WRITE_BURST)
  ) i_bus (
    .clk(clk), .rstN(rstN), .strobe(seqStrobe), .refGroup(refGroup),
    .sdCke(sdCke), .sdCsN(sdCsN), .sdRasN(sdRasN), .sdCasN(sdCasN), .sdWeN(sdWeN),
    .sdBa(sdBa), .sdAddr(sdAddr), .initDone(initDone)
  );

endmodule

// File: tb/test_sdram_powerup_init.sv
`timescale 1ns/1ps
module test_sdram_powerup_init;

  localparam int WAIT = 40;
  localparam int TRP  = 3;
  localparam int TRC  = 5;
  localparam int TMRD = 2;
  localparam int G    = 2;
  localparam int AW   = 13;
  localparam int BW   = 2;
  localparam int BL   = 4;
  localparam int BT   = 1;
  localparam int CL   = 3;
  localparam int WB   = 1;
  // R8 mode word from the requirement's field layout
  localparam int BL_CODE  = (BL == 1) ? 0 : (BL == 2) ? 1 : (BL == 4) ? 2 : 3;
  localparam int MODE_EXP = BL_CODE | (BT << 3) | (CL << 4) | (WB << 9);

  logic          clk = 1'b0;
  logic          rstN = 1'b0;
  logic          sdCke, sdRasN, sdCasN, sdWeN, initDone;
  logic [G-1:0]  sdCsN;
  logic [BW-1:0] sdBa;
  logic [AW-1:0] sdAddr;

  always #4 clk = ~clk;

  sdram_powerup_init #(
    .WAIT_CYC(WAIT), .T_RP(TRP), .T_RC(TRC), .T_MRD(TMRD), .GROUPS(G), .ADDR_W(AW),
    .BANK_W(BW), .BURST_LEN(BL), .BURST_TYPE(BT), .CAS_LAT(CL), .WRITE_BURST(WB)
  ) i_sdram_powerup_init (
    .clk(clk), .rstN(rstN), .sdCke(sdCke), .sdCsN(sdCsN), .sdRasN(sdRasN),
    .sdCasN(sdCasN), .sdWeN(sdWeN), .sdBa(sdBa), .sdAddr(sdAddr), .initDone(initDone)
  );

  typedef struct {
    int           cyc;
    int           kind;   // 0 precharge, 1 refresh, 2 mode load
    logic [2:0]   rcw;
    logic [G-1:0] cs;
    int           addr;
  } expCmd_t;

  expCmd_t q[$];
  int      expDone;
  int      cyc;
  int      checks = 0;
  int      errors = 0;
  bit      monEn = 0;

  always @(posedge clk) begin
    if (!rstN) cyc <= 0;
    else cyc <= cyc + 1;
  end

  task automatic check(input bit ok, input string req, input string what,
                       input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s at edge %0d: actual %0h expected %0h", req, what, cyc, act, exp);
    end
  endtask

  // Driver: push the expected command stream for one run from reset release
  task automatic planSequence();
    int t;
    expCmd_t e;
    q.delete();
    t = WAIT + 2;
    e.cyc = t; e.kind = 0; e.rcw = 3'b010; e.cs = '0; e.addr = 1 << 10;
    q.push_back(e);
    t += TRP;                                   // R6 precharge to first refresh
    for (int g = 0; g < G; g++) begin           // R5 ascending groups, two each
      for (int k = 0; k < 2; k++) begin
        e.cyc = t; e.kind = 1; e.rcw = 3'b001; e.cs = ~(G'(1) << g); e.addr = 0;
        q.push_back(e);
        t += TRC;
      end
    end
    e.cyc = t; e.kind = 2; e.rcw = 3'b000; e.cs = '0; e.addr = MODE_EXP;
    q.push_back(e);
    expDone = t + TMRD;
  endtask

  task automatic checkResetState(input string req);
    check(sdCsN == '1, req, "reset chip selects", int'(sdCsN), (1 << G) - 1);
    check({sdRasN, sdCasN, sdWeN} == 3'b111, req, "reset ras/cas/we",
          int'({sdRasN, sdCasN, sdWeN}), 7);
    check(sdCke == 1'b1, req, "reset cke", int'(sdCke), 1);
    check(initDone == 1'b0, req, "reset initDone", int'(initDone), 0);
  endtask

  // Monitor: compare the bus each cycle against the scoreboard queue
  always @(negedge clk) begin
    if (monEn) begin
      logic [2:0] rcw;
      rcw = {sdRasN, sdCasN, sdWeN};
      check(sdCke == 1'b1, "R9", "cke", int'(sdCke), 1);
      if (cyc <= WAIT) begin
        check(sdCsN == '1 && rcw == 3'b111, "R1", "inhibit during wait",
              int'({sdCsN, rcw}), int'({{G{1'b1}}, 3'b111}));
      end else if (q.size() > 0 && q[0].cyc == cyc) begin
        expCmd_t e;
        e = q.pop_front();
        case (e.kind)
          0: begin
            check(rcw == e.rcw, "R3", "precharge code", int'(rcw), int'(e.rcw));
            check(sdCsN == e.cs, "R3", "precharge selects", int'(sdCsN), int'(e.cs));
            check(int'(sdAddr) == e.addr && sdBa == '0, "R3", "precharge address",
                  int'(sdAddr), e.addr);
          end
          1: begin
            check(rcw == e.rcw, "R4", "refresh code", int'(rcw), int'(e.rcw));
            check(sdCsN == e.cs, "R5", "refresh group select", int'(sdCsN), int'(e.cs));
            check(int'(sdAddr) == 0 && sdBa == '0, "R4", "refresh address",
                  int'(sdAddr), 0);
          end
          default: begin
            check(rcw == e.rcw, "R7", "mode load code", int'(rcw), int'(e.rcw));
            check(sdCsN == e.cs && sdBa == '0, "R7", "mode load selects",
                  int'(sdCsN), int'(e.cs));
            check(int'(sdAddr) == e.addr, "R8", "mode word", int'(sdAddr), e.addr);
          end
        endcase
      end else begin
        // R6: commands off their scheduled edge show up here as non-NOP
        check(sdCsN == '0 && rcw == 3'b111, (cyc == WAIT + 1) ? "R2" : "R6",
              "nop between commands", int'({sdCsN, rcw}), 7);
      end
      check(initDone == (cyc >= expDone), "R10", "initDone", int'(initDone),
            int'(cyc >= expDone));
    end
  end

  task automatic runToDone();
    @(negedge clk) rstN = 1'b1;
    @(posedge clk);
    #1 monEn = 1;
    while (cyc < expDone + 10) @(negedge clk);
    @(posedge clk);
    #1 monEn = 0;
  endtask

  initial begin
    expDone = 1 << 30;
    repeat (3) @(negedge clk);
    checkResetState("R1");
    planSequence();
    runToDone();
    check(q.size() == 0, "R5", "all commands issued", q.size(), 0);

    // R11: reset in the middle of the refresh phase
    @(negedge clk) rstN = 1'b0;
    planSequence();
    @(negedge clk);
    runToDone();
    check(q.size() == 0, "R10", "second run complete", q.size(), 0);
    @(negedge clk) rstN = 1'b0;
    planSequence();
    repeat (2) @(negedge clk);
    rstN = 1'b1;
    @(posedge clk);
    #1 monEn = 1;
    while (cyc < WAIT + 2 + TRP + 2 * TRC) @(negedge clk);
    @(posedge clk);
    #1 monEn = 0;
    @(negedge clk) rstN = 1'b0;
    #1 checkResetState("R11");
    planSequence();
    repeat (2) @(negedge clk);
    runToDone();
    check(q.size() == 0, "R11", "restart completes sequence", q.size(), 0);
    check(initDone == 1'b1, "R11", "done after restart", int'(initDone), 1);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (5000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule